// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer with Capture and Pulse Generation

This peripheral holds one 16-bit up-counter and uses it in four ways, chosen by a 2-bit mode field. In compare mode the counter runs up to the value in data register A, returns to zero and inverts a toggle output. In capture mode the counter runs freely and a rising edge on an external event input copies the count into data register B. In the two pulse modes, A sets the period and B the high time of a PWM output. The PWM either runs once and stops or repeats without end.

The count tick comes from a free-running prescaler that divides the system clock by 1, 2, 4, 8, 32, 128 or 512. It can instead come from a match pulse supplied by a neighbouring timer. Software reaches a control byte and the two data registers, one byte at a time, through a simple write port and a combinational read port. The timer does nothing while its enable bit is clear.

Top module: `tmr16_top`

## Requirements
- R1: After reset the control byte, A and B all read 0, and `toggleOut`, `pwmOut` and `matchIrq` are low.
- R2: Address 0 is the control byte: bit 7 is enable, bits 5:4 are the mode (00 compare, 01 capture, 10 one-shot pulse, 11 repeat pulse) and bits 2:0 are the clock select. Bits 6 and 3 are stored and read back as written. Addresses 1 and 2 are the low and high bytes of A. Addresses 3 and 4 are the low and high bytes of B. A write takes effect at the next clock edge. `rdData` shows the addressed byte in the same cycle and reads 0 at addresses 5 to 7.
- R3: Clock-select values 0 to 6 give a tick every 1, 2, 4, 8, 32, 128 or 512 system clocks. The prescaler counts up from 0 from the cycle the timer is enabled. A tick is issued in each cycle where the prescaler's low log2(divisor) bits are all ones. Value 7 takes `extTick` as the tick, cycle for cycle.
- R4: In compare mode, a tick with the count equal to A clears the count to 0 and inverts `toggleOut`. Any other tick increments the count.
- R5: `matchIrq` is high for the one cycle after each tick that finds the count equal to A. This applies in compare mode and in both pulse modes (in a pulse mode only while the period is not finished). Consecutive matches give consecutive pulses.
- R6: In capture mode the count wraps from 0xFFFF to 0. `capIn` passes through a two-flop synchronizer. A rising edge of `capIn` present before clock edge k loads B, at edge k+2, with the count held just before that edge.
- R7: When a capture and a software write to a byte of B fall on the same edge, the captured value wins.
- R8: In a pulse mode, `pwmOut` is high while the count is below B and low otherwise. So B = 0 gives a constantly low output, and B > A gives a constantly high one.
- R9: In repeat pulse mode, a tick with the count equal to A returns the count to 0 and the waveform continues.
- R10: In one-shot pulse mode, a tick with the count equal to A freezes the counter and holds `pwmOut` low. This lasts until the timer is disabled or switched to another mode.
- R11: While enable is clear, `pwmOut` is low. One edge after enable is seen clear, the counter, the prescaler, `toggleOut`, `matchIrq` and the one-shot state are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extTick | input | 1 | Match pulse from a neighbouring timer, usable as count tick |
| capIn | input | 1 | External capture event, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write byte |
| rdAddr | input | 3 | Register read address |
| rdData | output | 8 | Addressed register byte |
| toggleOut | output | 1 | Compare-mode toggle output |
| pwmOut | output | 1 | Pulse/PWM output |
| matchIrq | output | 1 | One-cycle match interrupt pulse |

## Verification
Two functions can act on register B in the same cycle: a synchronized capture edge, and a software write to one of B's bytes. The bench raises `capIn` and then issues a write of a distinct pattern to B exactly two edges later, which lands on the capture edge. A reference model compares every clock against the read-back of B. The read-back must show the count and not the written pattern. The bench also switches a finished one-shot directly into repeat mode, where the stale finished flag and the new mode meet on one edge.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int CNT_BYTES = 2;
  localparam int CNT_W     = 8 * CNT_BYTES;
  localparam int ADDR_W    = 3;
  localparam int PRESC_W   = 9;
  localparam int REG_CTRL  = 0;
  localparam int REG_A_LO  = 1;
  localparam int REG_B_LO  = REG_A_LO + CNT_BYTES;

  typedef enum logic [1:0] {
    MODE_COMPARE = 2'b00,
    MODE_CAPTURE = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_REPEAT  = 2'b11
  } tmrMode_e;

  typedef struct packed {
    logic     en;
    tmrMode_e mode;
    logic     tick;
    logic     capture;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              extTick,
  input  logic              capIn,
  output tmrStrobe_t        strobe,
  output logic [7:0]        ctrlByte
);
  logic [7:0]           ctrlR;
  logic [PRESC_W-1:0]   prescR;
  logic [SYNC_STAGES:0] capSync;
  logic [PRESC_W-1:0]   divMask;
  logic                 prescTick;
  logic                 capEdge;
  logic                 ctrlWr;

  function automatic int selShift(input logic [2:0] sel);
    case (sel)
      3'd0:    return 0;
      3'd1:    return 1;
      3'd2:    return 2;
      3'd3:    return 3;
      3'd4:    return 5;
      3'd5:    return 7;
      default: return 9;
    endcase
  endfunction

  assign ctrlWr = wrEn && (wrAddr == ADDR_W'(REG_CTRL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlR   <= '0;
      prescR  <= '0;
      capSync <= '0;
    end else begin
      if (ctrlWr) ctrlR <= wrData;
      prescR  <= ctrlR[7] ? prescR + 1'b1 : '0;
      capSync <= {capSync[SYNC_STAGES-1:0], capIn};
    end
  end

  always_comb begin
    divMask   = PRESC_W'((32'd1 << selShift(ctrlR[2:0])) - 32'd1);
    prescTick = (prescR & divMask) == divMask;
    capEdge   = capSync[SYNC_STAGES-1] && !capSync[SYNC_STAGES];
    strobe.en      = ctrlR[7];
    strobe.mode    = tmrMode_e'(ctrlR[5:4]);
    strobe.tick    = ctrlR[7] && ((ctrlR[2:0] == 3'd7) ? extTick : prescTick);
    strobe.capture = ctrlR[7] && (ctrlR[5:4] == MODE_CAPTURE) && capEdge;
  end

  assign ctrlByte = ctrlR;

  // R3: divide-by-two never ticks on two cycles in a row
  a_r3_div2_gap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && ctrlR[2:0] == 3'd1 && !ctrlWr) |=> !strobe.tick);

  // R11: prescaler is cleared while disabled
  a_r11_presc_clear: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.en |=> (prescR == '0));
endmodule

// File: rtl/tmr16_dpath.sv
module tmr16_dpath
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic [CNT_W-1:0]  regA,
  output logic [CNT_W-1:0]  regB,
  output logic              toggleOut,
  output logic              pwmOut,
  output logic              matchIrq
);
  logic [CNT_W-1:0] cntR;
  logic [CNT_W-1:0] aNext;
  logic [CNT_W-1:0] bNext;
  logic             doneR;
  logic             togR;
  logic             irqR;

  always_comb begin
    aNext = regA;
    bNext = regB;
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (wrEn && wrAddr == ADDR_W'(REG_A_LO + b)) aNext[b*8 +: 8] = wrData;
      if (wrEn && wrAddr == ADDR_W'(REG_B_LO + b)) bNext[b*8 +: 8] = wrData;
    end
    if (strobe.capture) bNext = cntR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
    end else begin
      regA <= aNext;
      regB <= bNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntR  <= '0;
      doneR <= 1'b0;
      togR  <= 1'b0;
      irqR  <= 1'b0;
    end else if (!strobe.en) begin
      cntR  <= '0;
      doneR <= 1'b0;
      togR  <= 1'b0;
      irqR  <= 1'b0;
    end else begin
      irqR <= 1'b0;
      if (strobe.mode != MODE_ONESHOT) doneR <= 1'b0;
      if (strobe.tick) begin
        case (strobe.mode)
          MODE_COMPARE: begin
            if (cntR == regA) begin
              cntR <= '0;
              togR <= ~togR;
              irqR <= 1'b1;
            end else begin
              cntR <= cntR + 1'b1;
            end
          end
          MODE_CAPTURE: cntR <= cntR + 1'b1;
          default: begin
            if (!doneR) begin
              if (cntR == regA) begin
                irqR <= 1'b1;
                if (strobe.mode == MODE_REPEAT) cntR  <= '0;
                else                            doneR <= 1'b1;
              end else begin
                cntR <= cntR + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  assign toggleOut = togR;
  assign matchIrq  = irqR;
  assign pwmOut    = strobe.en && strobe.mode[1] && !doneR && (cntR < regB);

  // R6: a capture loads B with the count seen on that edge
  a_r6_capture_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (regB == $past(cntR)));

  // R7: a write to B's low byte on a capture edge loses to the capture
  a_r7_capture_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && wrEn && wrAddr == ADDR_W'(REG_B_LO)) |=> (regB[7:0] == $past(cntR[7:0])));

  // R10: a finished one-shot keeps its count
  a_r10_oneshot_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.en && strobe.mode == MODE_ONESHOT && doneR) |=> $stable(cntR));

  // R5: an interrupt pulse always follows a tick
  a_r5_irq_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    matchIrq |-> $past(strobe.tick));

  // R11: disabling clears the count and quiets the outputs
  a_r11_off_clear: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.en |=> (cntR == '0 && !toggleOut && !matchIrq));
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              extTick,
  input  logic              capIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              toggleOut,
  output logic              pwmOut,
  output logic              matchIrq
);
  tmrStrobe_t       strobe;
  logic [7:0]       ctrlByte;
  logic [CNT_W-1:0] regA;
  logic [CNT_W-1:0] regB;

  tmr16_ctrl #(.SYNC_STAGES(2)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extTick(extTick), .capIn(capIn), .strobe(strobe), .ctrlByte(ctrlByte)
  );

  tmr16_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .regA(regA), .regB(regB), .toggleOut(toggleOut),
    .pwmOut(pwmOut), .matchIrq(matchIrq)
  );

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(REG_CTRL)) rdData = ctrlByte;
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (rdAddr == ADDR_W'(REG_A_LO + b)) rdData = regA[b*8 +: 8];
      if (rdAddr == ADDR_W'(REG_B_LO + b)) rdData = regB[b*8 +: 8];
    end
  end
endmodule

// File: tb/tmr16_tb.sv
module tmr16_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extTick = 1'b0;
  logic       capIn = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       toggleOut, pwmOut, matchIrq;

  int    checks = 0;
  int    failures = 0;
  bit    comparing = 1'b0;
  bit    finished = 1'b0;
  string curReq = "R1";

  logic [7:0]  mCtrl;
  logic [15:0] mA, mB, mCnt;
  int          mPresc;
  bit          mDone, mTog, mIrq, ms1, ms2, ms3;

  always #4 clk = ~clk;

  tmr16_top dut_i (
    .clk(clk), .rstN(rstN), .extTick(extTick), .capIn(capIn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .toggleOut(toggleOut), .pwmOut(pwmOut), .matchIrq(matchIrq)
  );

  function automatic int divShift(input logic [2:0] s);
    int t[7] = '{0, 1, 2, 3, 5, 7, 9};
    return (s < 7) ? t[s] : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mA = 0; mB = 0; mCnt = 0; mPresc = 0;
      mDone = 0; mTog = 0; mIrq = 0; ms1 = 0; ms2 = 0; ms3 = 0;
    end else begin
      bit capEdge, en, tick, capNow;
      logic [1:0] mode;
      logic [15:0] oldCnt;
      int dv;
      capEdge = ms2 && !ms3;
      ms3 = ms2; ms2 = ms1; ms1 = capIn;
      en = mCtrl[7]; mode = mCtrl[5:4];
      dv = 1 << divShift(mCtrl[2:0]);
      tick = en && ((mCtrl[2:0] == 3'd7) ? extTick : ((mPresc % dv) == dv - 1));
      oldCnt = mCnt;
      capNow = en && (mode == 2'b01) && capEdge;
      if (!en) begin
        mCnt = 0; mPresc = 0; mTog = 0; mDone = 0; mIrq = 0;
      end else begin
        mPresc = (mPresc + 1) % 512;
        mIrq = 0;
        if (tick) begin
          if (mode == 2'b00) begin
            if (mCnt == mA) begin mCnt = 0; mTog = !mTog; mIrq = 1; end
            else mCnt = mCnt + 16'd1;
          end else if (mode == 2'b01) begin
            mCnt = mCnt + 16'd1;
          end else if (!mDone) begin
            if (mCnt == mA) begin
              mIrq = 1;
              if (mode == 2'b11) mCnt = 0; else mDone = 1;
            end else mCnt = mCnt + 16'd1;
          end
        end
        if (mode != 2'b10) mDone = 0;
      end
      if (wrEn) begin
        case (wrAddr)
          3'd0: mCtrl = wrData;
          3'd1: mA[7:0] = wrData;
          3'd2: mA[15:8] = wrData;
          3'd3: if (!capNow) mB[7:0] = wrData;
          3'd4: if (!capNow) mB[15:8] = wrData;
          default: ;
        endcase
      end
      if (capNow) mB = oldCnt;
    end
  end

  function automatic logic [7:0] expRd(input logic [2:0] a);
    case (a)
      3'd0: return mCtrl;
      3'd1: return mA[7:0];
      3'd2: return mA[15:8];
      3'd3: return mB[7:0];
      3'd4: return mB[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #2;
    if (rstN && comparing) begin
      bit expPwm;
      expPwm = mCtrl[7] && mCtrl[5] && !mDone && (mCnt < mB);
      chk(curReq, "toggleOut", toggleOut, mTog);
      chk(curReq, "pwmOut", pwmOut, expPwm);
      chk(curReq, "matchIrq", matchIrq, mIrq);
      chk(curReq, "rdData", rdData, expRd(rdAddr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
    wr(lo, v[7:0]);
    wr(lo + 3'd1, v[15:8]);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rdAddr = 3'(a);
      #1;
      chk("R1", "rdData after reset", rdData, 0);
    end
    chk("R1", "outputs after reset", {toggleOut, pwmOut, matchIrq}, 0);
    comparing = 1'b1;

    // R2: register map read-back, timer disabled
    curReq = "R2";
    wr16(3'd1, 16'h1234);
    wr16(3'd3, 16'hBEEF);
    wr(3'd0, 8'h7D);
    for (int a = 0; a < 8; a++) begin rdAddr = 3'(a); run(1); end
    rdAddr = 3'd0; #1;
    chk("R2", "control byte", rdData, 8'h7D);

    // R4: compare mode, divide by one
    curReq = "R4";
    wr16(3'd1, 16'd5);
    wr(3'd0, 8'h80);
    run(40);

    // R3: prescaler settings and external tick
    curReq = "R3";
    wr16(3'd1, 16'd3);
    wr(3'd0, 8'h81); run(60);
    wr(3'd0, 8'h82); run(60);
    wr(3'd0, 8'h83); run(100);
    wr(3'd0, 8'h84); run(300);
    wr(3'd0, 8'h85); run(1100);
    wr(3'd0, 8'h86); run(2200);
    wr(3'd0, 8'h87);
    for (int i = 0; i < 80; i++) begin
      extTick = (i % 3 == 0) || (i % 7 == 0);
      @(negedge clk);
    end
    extTick = 1'b0;

    // R5: A = 0 matches on every tick
    curReq = "R5";
    wr16(3'd1, 16'd0);
    wr(3'd0, 8'h80); run(12);
    wr(3'd0, 8'h82); run(20);

    // R11: disable clears everything
    curReq = "R11";
    wr(3'd0, 8'h00); run(10);
    wr(3'd0, 8'h80); run(5);
    wr(3'd0, 8'h00); run(5);

    // R6: capture mode, edges and wrap
    curReq = "R6";
    rdAddr = 3'd3;
    wr(3'd0, 8'h90);
    for (int k = 0; k < 4; k++) begin
      run(7 + k * 5);
      capIn = 1'b1; run(3);
      capIn = 1'b0; rdAddr = (rdAddr == 3'd3) ? 3'd4 : 3'd3;
    end
    run(66000);
    capIn = 1'b1; run(4); capIn = 1'b0; run(3);
    rdAddr = 3'd4; run(2);

    // R7: capture edge meets a write to B
    curReq = "R7";
    rdAddr = 3'd3;
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h90);
    run(5);
    capIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(3'd3, 8'hAA);
    capIn = 1'b0;
    run(3);
    #1;
    chk("R7", "B low after collision", (rdData == 8'hAA) ? 1 : 0, 0);

    // R8: duty cases in repeat mode
    curReq = "R8";
    rdAddr = 3'd0;
    wr(3'd0, 8'h00);
    wr16(3'd1, 16'd9); wr16(3'd3, 16'd4);
    wr(3'd0, 8'hB0); run(40);
    wr16(3'd3, 16'd0); run(25);
    wr16(3'd3, 16'd12); run(25);

    // R9: repeat wrap with a divided tick
    curReq = "R9";
    wr16(3'd3, 16'd2);
    wr(3'd0, 8'hB1); run(60);

    // R10: one-shot, restart, then switch to repeat while finished
    curReq = "R10";
    wr(3'd0, 8'h00);
    wr16(3'd1, 16'd6); wr16(3'd3, 16'd3);
    wr(3'd0, 8'hA0); run(30);
    wr(3'd0, 8'h00); run(3);
    wr(3'd0, 8'hA0); run(20);
    wr(3'd0, 8'hB0); run(25);

    comparing = 1'b0;
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired in %s", curReq);
      summary();
      $finish;
    end
  end
endmodule